// File: doc/BRIEF.md
# Asynchronous Target Byte Sender with Parity

This block moves a stream of bytes from a bus target to the initiator over a fully interlocked, active-low request/acknowledge handshake. Each byte arrives on a valid/ready input, gets a parity bit, and is placed on a nine-line data bus together with an output-enable. The block then waits a counted number of clock cycles so the data can settle. It asserts the request line only when the acknowledge line is seen released. It holds the request until acknowledge is seen asserted, and then frees the request so the next byte can go out.

The acknowledge input comes from another clock domain and passes through a synchronizer chain before the sequencer uses it. The setup count, the synchronizer depth, the data width and the parity sense are parameters. Between bytes the block keeps the last byte on the bus with the request released, and it reports itself idle. The stream should hold an even number of bytes in total. That count is the caller's responsibility.

Top module: `scsi_tgt_async_tx`

## Requirements
- R1: After reset, `req_n` is high, `bus_oe` is low, `busy` and `done` are low, `in_ready` is high and `bus_out` is zero.
- R2: For an accepted byte, `bus_out[7:0]` carries the byte and `bus_out[8]` carries the parity bit. With the default odd sense, the nine bits hold an odd number of ones.
- R3: When `ack_n` has been high for a while, `req_n` falls exactly SETUP_CYCLES clock cycles after the cycle in which the new byte appears on `bus_out`.
- R4: `req_n` is not asserted while the synchronized acknowledge is low. Once `ack_n` rises after the setup count has run out, `req_n` falls on the (SYNC_STAGES+1)-th rising clock edge after the change.
- R5: Once asserted, `req_n` stays low until acknowledge is seen low. It rises on the (SYNC_STAGES+1)-th rising clock edge after `ack_n` falls.
- R6: `bus_out` does not change from the cycle after a byte is accepted until the request is released.
- R7: `in_ready` is high only when the block is idle. A byte is accepted only on a clock edge where `in_valid` and `in_ready` are both high.
- R8: While idle, `req_n` stays high, `busy` is low and `bus_out` keeps the last byte sent.
- R9: `done` is high for exactly one cycle, namely the cycle in which `req_n` has just been released.
- R10: `bus_oe` rises with the first accepted byte and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| ack_n | input | 1 | Acknowledge from initiator, active low, asynchronous |
| bus_out | output | 9 | Data bits 7:0 and parity bit 8 |
| bus_oe | output | 1 | Drive enable for the data bus |
| req_n | output | 1 | Request to initiator, active low |
| busy | output | 1 | A byte handshake is in progress |
| done | output | 1 | One-cycle pulse when a byte completes |

## Verification
The hardest case to reach is the one where the setup count runs out while the initiator is still holding acknowledge low from the previous byte. The request must then wait on the acknowledge line rather than on the counter. To create it, the bench's initiator model keeps `ack_n` low after one byte completes and offers the next byte. It watches for twenty cycles that no request appears, and then releases acknowledge and times the request from that edge. All 256 byte values are also swept to check parity and the exact setup spacing.

// File: rtl/scsi_tx_pkg.sv
package scsi_tx_pkg;
   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_SETUP = 2'd1,
      TX_REQ   = 2'd2
   } tx_state_t;
endpackage

// File: rtl/tx_ack_sync.sv
module tx_ack_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tx_ack_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RESET_VAL;
            else        chain[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RESET_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/tx_parity_gen.sv
module tx_parity_gen #(
   parameter int DATA_W = 8,
   parameter bit ODD    = 1'b1
) (
   input  logic [DATA_W-1:0] data,
   output logic              par
);
   if (DATA_W < 1) begin : g_bad_width
      $error("tx_parity_gen: DATA_W must be positive");
   end

   if (ODD) begin : g_odd
      assign par = ~(^data);
   end else begin : g_even
      assign par = ^data;
   end
endmodule

// File: rtl/tx_setup_timer.sv
module tx_setup_timer #(
   parameter int CYCLES = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("tx_setup_timer: CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (load)            cnt <= LOAD_VAL;
      else if (cnt != '0)       cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/tx_handshake_fsm.sv
module tx_handshake_fsm
   import scsi_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_par,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              ack_sync,
   input  logic              timer_expired,
   output logic              timer_load,
   output logic [DATA_W:0]   bus_q,
   output logic              oe_q,
   output logic              req_n_q,
   output logic              busy,
   output logic              done_q
);
   tx_state_t state;

   assign in_ready   = (state == TX_IDLE);
   assign busy       = (state != TX_IDLE);
   assign timer_load = in_ready && in_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= TX_IDLE;
         bus_q   <= '0;
         oe_q    <= 1'b0;
         req_n_q <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            TX_IDLE: begin
               if (in_valid) begin
                  bus_q <= {in_par, in_data};
                  oe_q  <= 1'b1;
                  state <= TX_SETUP;
               end
            end
            TX_SETUP: begin
               if (timer_expired && ack_sync) begin
                  req_n_q <= 1'b0;
                  state   <= TX_REQ;
               end
            end
            TX_REQ: begin
               if (!ack_sync) begin
                  req_n_q <= 1'b1;
                  done_q  <= 1'b1;
                  state   <= TX_IDLE;
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/scsi_tgt_async_tx.sv
module scsi_tgt_async_tx #(
   parameter int DATA_W       = 8,
   parameter int SETUP_CYCLES = 9,
   parameter int SYNC_STAGES  = 2,
   parameter bit ODD_PARITY   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              ack_n,
   output logic [DATA_W:0]   bus_out,
   output logic              bus_oe,
   output logic              req_n,
   output logic              busy,
   output logic              done
);
   localparam int BUS_W = DATA_W + 1;

   if (SETUP_CYCLES < 1) begin : g_bad_setup
      $error("scsi_tgt_async_tx: SETUP_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("scsi_tgt_async_tx: SYNC_STAGES must be at least 2");
   end

   logic ack_sync;
   logic par;
   logic timer_load;
   logic timer_expired;

   tx_ack_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ack_n),
      .dout  (ack_sync)
   );

   tx_parity_gen #(
      .DATA_W (DATA_W),
      .ODD    (ODD_PARITY)
   ) u_parity (
      .data (in_data),
      .par  (par)
   );

   tx_setup_timer #(
      .CYCLES (SETUP_CYCLES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (timer_load),
      .expired (timer_expired)
   );

   tx_handshake_fsm #(
      .DATA_W (DATA_W)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_data       (in_data),
      .in_par        (par),
      .in_valid      (in_valid),
      .in_ready      (in_ready),
      .ack_sync      (ack_sync),
      .timer_expired (timer_expired),
      .timer_load    (timer_load),
      .bus_q         (bus_out),
      .oe_q          (bus_oe),
      .req_n_q       (req_n),
      .busy          (busy),
      .done_q        (done)
   );

   logic [BUS_W-1:0] unused_width_probe;
   assign unused_width_probe = bus_out;
endmodule

// File: rtl/scsi_tgt_async_tx_chk.sv
module scsi_tgt_async_tx_chk #(
   parameter int BUS_W       = 9,
   parameter int SYNC_STAGES = 2,
   parameter bit ODD_PARITY  = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_ready,
   input logic             ack_n,
   input logic [BUS_W-1:0] bus_out,
   input logic             bus_oe,
   input logic             req_n,
   input logic             busy,
   input logic             done
);
   logic [7:0] ack_hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ack_hi_cnt <= '0;
      else if (!ack_n)            ack_hi_cnt <= '0;
      else if (ack_hi_cnt != '1)  ack_hi_cnt <= ack_hi_cnt + 1'b1;
   end

   a_r2_parity_sense: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> ((^bus_out) == ODD_PARITY));

   a_r4_req_after_ack_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_n) |-> ($past(ack_hi_cnt) >= 8'(SYNC_STAGES)));

   a_r5_req_rise_is_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_n) |-> done);

   a_r6_bus_stable_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy) |-> $stable(bus_out));

   a_r7_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !busy);

   a_r8_idle_req_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> req_n);

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_oe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_oe) |-> bus_oe);
endmodule

bind scsi_tgt_async_tx scsi_tgt_async_tx_chk #(
   .BUS_W       (BUS_W),
   .SYNC_STAGES (SYNC_STAGES),
   .ODD_PARITY  (ODD_PARITY)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_ready (in_ready),
   .ack_n    (ack_n),
   .bus_out  (bus_out),
   .bus_oe   (bus_oe),
   .req_n    (req_n),
   .busy     (busy),
   .done     (done)
);

// File: tb/scsi_tgt_async_tx_tb.sv
`timescale 1ns/1ps
module scsi_tgt_async_tx_tb;
   localparam int SETUP = 9;
   localparam int SYNC  = 2;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] in_data;
   logic       in_valid;
   logic       in_ready;
   logic       ack_n;
   logic [8:0] bus_out;
   logic       bus_oe;
   logic       req_n;
   logic       busy;
   logic       done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   scsi_tgt_async_tx #(
      .DATA_W (8), .SETUP_CYCLES (SETUP), .SYNC_STAGES (SYNC), .ODD_PARITY (1'b1)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .in_data (in_data), .in_valid (in_valid),
      .in_ready (in_ready), .ack_n (ack_n), .bus_out (bus_out), .bus_oe (bus_oe),
      .req_n (req_n), .busy (busy), .done (done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [8:0] expect_bus(input logic [7:0] b);
      return {~(^b), b};
   endfunction

   task automatic offer(input logic [7:0] b);
      @(negedge clk);
      in_data  = b;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(bus_out == expect_bus(b), "R2 bus layout", int'(bus_out), int'(expect_bus(b)));
      check(!in_ready && busy, "R7 ready low while busy", int'(in_ready), 0);
   endtask

   task automatic wait_req(input logic level, output int k);
      k = 0;
      while (req_n != level && k < 200) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic finish_handshake(input logic [8:0] exp_bus, input bit hold_ack);
      int k;
      ack_n = 1'b0;
      wait_req(1'b1, k);
      check(k == SYNC + 1, "R5 release delay", k, SYNC + 1);
      check(done && !busy && in_ready, "R9 done at release", int'(done), 1);
      check(bus_out == exp_bus, "R6 bus held through handshake", int'(bus_out), int'(exp_bus));
      if (!hold_ack) ack_n = 1'b1;
      @(negedge clk);
      check(!done, "R9 done one cycle", int'(done), 0);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit hold_ack);
      int k;
      offer(b);
      wait_req(1'b0, k);
      check(k == SETUP, "R3 setup spacing", k, SETUP);
      finish_handshake(expect_bus(b), hold_ack);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int k;
      rst_n = 1'b0; ack_n = 1'b1; in_valid = 1'b0; in_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(req_n && !bus_oe && !busy && !done && in_ready && bus_out == '0,
            "R1 reset state", int'(bus_out), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // exhaustive sweep of byte values: R2, R3, R5, R6, R9
      for (int b = 0; b < 256; b++) begin
         send_byte(8'(b), 1'b0);
         if (b == 0) check(bus_oe, "R10 oe after first byte", int'(bus_oe), 1);
      end

      // R8: idle keeps last byte, req high; ack left low
      send_byte(8'hA5, 1'b1);
      repeat (5) @(negedge clk);
      check(req_n && !busy && !done && bus_out == expect_bus(8'hA5),
            "R8 idle hold", int'(bus_out), int'(expect_bus(8'hA5)));

      // R4: setup expires while ack still low
      offer(8'h3C);
      repeat (20) @(negedge clk);
      check(req_n == 1'b1, "R4 no request while ack low", int'(req_n), 1);
      check(bus_out == expect_bus(8'h3C), "R6 bus stable waiting", int'(bus_out),
            int'(expect_bus(8'h3C)));
      ack_n = 1'b1;
      wait_req(1'b0, k);
      check(k == SYNC + 1, "R4 request after ack rise", k, SYNC + 1);
      finish_handshake(expect_bus(8'h3C), 1'b0);

      // R7: no acceptance without valid
      in_data = 8'hFF;
      repeat (6) @(negedge clk);
      check(!busy && bus_out == expect_bus(8'h3C), "R7 nothing taken without valid",
            int'(bus_out), int'(expect_bus(8'h3C)));
      check(bus_oe, "R10 oe stays high", int'(bus_oe), 1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule